// File: doc/BRIEF.md
# Branch Direction Predictor with Selectable Indexing

This block predicts whether a conditional branch is taken for the fetch stage of an in-order processor. Every prediction comes from a 2-bit saturating counter. The counters are held in byte-wide storage, with four counters packed into each byte. A build-time parameter chooses one of four indexing schemes:

- bimodal, indexed by the PC alone;
- gselect, which concatenates PC bits with history bits;
- gshare, which XORs the PC with the history;
- tournament, in which a chooser table picks between a bimodal component and a gshare component.

Fetch presents a PC on the lookup port and receives the taken/not-taken answer on the next cycle. In that same cycle, the predicted direction is shifted into the global history register. Fetch reads `ghist` at lookup time and keeps that value as a snapshot for the branch. When the branch resolves, the update port receives the PC, the real outcome and the snapshot, and a read-modify-write trains the counters. If the branch was mispredicted, the history is rebuilt from the snapshot followed by the real outcome.

Top module: `bp_predictor`

## Requirements
- R1: After reset every counter, including every chooser counter, holds 1 (weakly not taken). `ghist` is 0 and `pred_valid` is 0, so the first lookup predicts not taken.
- R2: `pred_valid` equals the `lookup_valid` of the previous cycle. `pred_taken` is bit 1 of the selected counter at lookup time and holds its value in cycles with no lookup.
- R3: An update increments the trained counter when the outcome is taken and decrements it when not taken. The counter saturates at 3 and at 0.
- R4: An update rewrites its storage byte with only the addressed 2-bit field changed. Counter index bits [1:0] select the field, so the counters of PC+4, PC+8 and PC+12 in the same byte are untouched.
- R5: With IDX_W = log2(ENTRIES) and w = pc[IDX_W+1:2], the index schemes are as follows. Bimodal uses w. Gshare uses w XOR the zero-extended history. Gselect uses {w[IDX_W-G-1:0], history[G-1:0]} with G = HIST_W/2.
- R6: In tournament mode, a chooser counter of 2 or more (indexed like bimodal) selects the gshare prediction, and any lower value selects the bimodal prediction.
- R7: A lookup without a same-cycle mispredict update shifts `ghist` left by one, with the predicted direction entering bit 0 one cycle later.
- R8: An update flagged as mispredicted sets `ghist` to {snapshot[HIST_W-2:0], outcome} on the next cycle. This restore takes priority over a lookup shift in the same cycle.
- R9: A lookup reads the counters as they stood before any update in the same cycle. The update becomes visible to lookups from the next cycle.
- R10: In tournament mode, each update trains both the bimodal and the gshare component. The chooser moves toward the correct component only when the two components predicted differently before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_pc | input | PC_W | Fetch PC to predict |
| pred_valid | output | 1 | Prediction result valid |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| ghist | output | HIST_W | Current global history (snapshot source) |
| upd_valid | input | 1 | Resolved branch update this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_hist | input | HIST_W | History snapshot taken at prediction time |
| upd_mispredict | input | 1 | The branch was mispredicted; restore history |

## Verification
A lookup's answer and its history shift both appear one clock edge after the lookup is presented. An update changes the counters at that same edge, so the change is first seen by a lookup driven in the following cycle. The bench drives every input at a falling edge and samples `pred_valid`, `pred_taken` and `ghist` at the next falling edge, which lies exactly one rising edge later. Its model computes each expected value from counter state as it stood before that cycle's update. Two instances run on shared stimulus, one in tournament mode and one in gselect mode, and each instance's history is modelled separately.

// File: rtl/bp_pkg.sv
// Shared types and helpers for the branch direction predictor.
// Assumes 2-bit counters where bit 1 is the predicted direction.
package bp_pkg;
    typedef enum logic [1:0] {
        SCHEME_BIMODAL    = 2'd0,
        SCHEME_GSELECT    = 2'd1,
        SCHEME_GSHARE     = 2'd2,
        SCHEME_TOURNAMENT = 2'd3
    } scheme_e;

    localparam logic [1:0] CTR_INIT = 2'b01;

    // Saturating step of a 2-bit counter toward taken (up=1) or not taken.
    function automatic logic [1:0] ctr_next(input logic [1:0] c, input logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        else    return (c == 2'd0) ? c : c - 2'd1;
    endfunction
endpackage

// File: rtl/bp_index.sv
// Counter index generator for one table.
// KIND picks the bimodal, gselect or gshare formula.
// Assumes HIST_W <= IDX_W and GSEL_W < IDX_W.
module bp_index #(
    parameter int IDX_W  = 9,
    parameter int HIST_W = 8,
    parameter int GSEL_W = 4,
    parameter bp_pkg::scheme_e KIND = bp_pkg::SCHEME_BIMODAL
) (
    input  logic [IDX_W-1:0]  pc_word,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    generate
        if (KIND == bp_pkg::SCHEME_GSHARE) begin : g_gshare
            // XOR word address with zero-extended history
            assign idx = pc_word ^ IDX_W'(hist);
        end else if (KIND == bp_pkg::SCHEME_GSELECT) begin : g_gselect
            // Low PC bits above, low history bits below
            assign idx = {pc_word[IDX_W-GSEL_W-1:0], hist[GSEL_W-1:0]};
        end else begin : g_bimodal
            logic [HIST_W-1:0] hist_unused;
            assign hist_unused = hist;
            assign idx = pc_word;
        end
    endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
// Table of 2-bit counters packed four to a byte.
// One combinational read port for lookup and one read-modify-write port for update.
// The write stores the whole byte with only the addressed field stepped.
// Assumes ENTRIES is a multiple of 4.
module bp_ctr_table #(
    parameter int ENTRIES = 512,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up,
    output logic [1:0]       wr_ctr_old
);
    localparam int WORDS  = ENTRIES / 4;
    localparam int WORD_W = IDX_W - 2;

    logic [7:0] mem [WORDS];
    logic [7:0] rd_byte, wr_byte_old, wr_byte_new;
    logic [WORD_W-1:0] wr_word;

    // Lookup read: pick the byte, then the 2-bit field.
    always_comb begin
        rd_byte = mem[rd_idx[IDX_W-1:2]];
        rd_ctr  = rd_byte[{rd_idx[1:0], 1'b0} +: 2];
    end

    // Update read and merge: step the addressed field, keep the other three.
    always_comb begin
        wr_word     = wr_idx[IDX_W-1:2];
        wr_byte_old = mem[wr_word];
        wr_ctr_old  = wr_byte_old[{wr_idx[1:0], 1'b0} +: 2];
        for (int f = 0; f < 4; f++) begin
            wr_byte_new[2*f +: 2] = (wr_idx[1:0] == 2'(f))
                ? bp_pkg::ctr_next(wr_byte_old[2*f +: 2], wr_up)
                : wr_byte_old[2*f +: 2];
        end
    end

    // Storage: reset to weakly not taken, else write the merged byte back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= {4{bp_pkg::CTR_INIT}};
        end else if (wr_en) begin
            mem[wr_word] <= wr_byte_new;
        end
    end
endmodule

// File: rtl/bp_predictor.sv
// Branch direction predictor.
// Lookup result and history shift are registered, one cycle after the request.
// Updates do a read-modify-write of counters in the same cycle they arrive.
// Assumes the caller snapshots ghist at lookup time and returns it with the update.
module bp_predictor #(
    parameter bp_pkg::scheme_e SCHEME = bp_pkg::SCHEME_TOURNAMENT,
    parameter int ENTRIES = 512,
    parameter int HIST_W  = 8,
    parameter int PC_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_valid,
    input  logic [PC_W-1:0]   lookup_pc,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic [HIST_W-1:0] ghist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_mispredict
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int GSEL_W = HIST_W / 2;

    logic [IDX_W-1:0]  l_word, u_word;
    logic              pred_now;
    logic [HIST_W-1:0] ghr;

    assign l_word = lookup_pc[IDX_W+1:2];
    assign u_word = upd_pc[IDX_W+1:2];

    generate
        if (SCHEME == bp_pkg::SCHEME_TOURNAMENT) begin : g_tour
            logic [IDX_W-1:0] l_bi, l_gi, u_bi, u_gi;
            logic [1:0] l_bim, l_gsh, l_cho, u_bim, u_gsh, u_cho;
            logic disagree;

            bp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .GSEL_W(GSEL_W), .KIND(bp_pkg::SCHEME_BIMODAL))
                u_lbi (.pc_word(l_word), .hist(ghr), .idx(l_bi));
            bp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .GSEL_W(GSEL_W), .KIND(bp_pkg::SCHEME_GSHARE))
                u_lgi (.pc_word(l_word), .hist(ghr), .idx(l_gi));
            bp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .GSEL_W(GSEL_W), .KIND(bp_pkg::SCHEME_BIMODAL))
                u_ubi (.pc_word(u_word), .hist(upd_hist), .idx(u_bi));
            bp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .GSEL_W(GSEL_W), .KIND(bp_pkg::SCHEME_GSHARE))
                u_ugi (.pc_word(u_word), .hist(upd_hist), .idx(u_gi));

            // The chooser trains only when the components disagree.
            assign disagree = u_bim[1] ^ u_gsh[1];

            bp_ctr_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_bim_tbl (
                .clk(clk), .rst_n(rst_n), .rd_idx(l_bi), .rd_ctr(l_bim),
                .wr_en(upd_valid), .wr_idx(u_bi), .wr_up(upd_taken), .wr_ctr_old(u_bim));
            bp_ctr_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_gsh_tbl (
                .clk(clk), .rst_n(rst_n), .rd_idx(l_gi), .rd_ctr(l_gsh),
                .wr_en(upd_valid), .wr_idx(u_gi), .wr_up(upd_taken), .wr_ctr_old(u_gsh));
            bp_ctr_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cho_tbl (
                .clk(clk), .rst_n(rst_n), .rd_idx(l_bi), .rd_ctr(l_cho),
                .wr_en(upd_valid && disagree), .wr_idx(u_bi),
                .wr_up(u_gsh[1] == upd_taken), .wr_ctr_old(u_cho));

            // The chooser's upper bit selects the gshare component.
            assign pred_now = l_cho[1] ? l_gsh[1] : l_bim[1];
        end else begin : g_single
            logic [IDX_W-1:0] l_idx, u_idx;
            logic [1:0] l_ctr, u_ctr;

            bp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .GSEL_W(GSEL_W), .KIND(SCHEME))
                u_li (.pc_word(l_word), .hist(ghr), .idx(l_idx));
            bp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .GSEL_W(GSEL_W), .KIND(SCHEME))
                u_ui (.pc_word(u_word), .hist(upd_hist), .idx(u_idx));

            bp_ctr_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tbl (
                .clk(clk), .rst_n(rst_n), .rd_idx(l_idx), .rd_ctr(l_ctr),
                .wr_en(upd_valid), .wr_idx(u_idx), .wr_up(upd_taken), .wr_ctr_old(u_ctr));

            assign pred_now = l_ctr[1];
        end
    endgenerate

    // Prediction register and global history: a restore beats a speculative shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghr        <= '0;
            pred_valid <= 1'b0;
            pred_taken <= 1'b0;
        end else begin
            pred_valid <= lookup_valid;
            if (lookup_valid) pred_taken <= pred_now;
            if (upd_valid && upd_mispredict)
                ghr <= {upd_hist[HIST_W-2:0], upd_taken};
            else if (lookup_valid)
                ghr <= {ghr[HIST_W-2:0], pred_now};
        end
    end

    assign ghist = ghr;
endmodule

// File: rtl/bp_predictor_chk.sv
// Port-level protocol checks for bp_predictor, attached by bind.
module bp_predictor_chk #(
    parameter int HIST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lookup_valid,
    input logic              pred_valid,
    input logic              pred_taken,
    input logic [HIST_W-1:0] ghist,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] upd_hist,
    input logic              upd_mispredict
);
    logic restore;
    assign restore = upd_valid && upd_mispredict;

    // R2: the valid flag follows the lookup by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> pred_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !pred_valid);
    // R2: the direction holds when there is no lookup
    a_r2_hold_pred: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> $stable(pred_taken));
    // R7: the speculative shift enters the same direction that was predicted
    a_r7_shift_in_pred: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && !restore) |=> (ghist[0] == pred_taken));
    a_r7_shift_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && !restore) |=> (ghist[HIST_W-1:1] == $past(ghist[HIST_W-2:0])));
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!lookup_valid && !restore) |=> $stable(ghist));
    // R8: a mispredict rebuilds history from the snapshot and the outcome
    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (ghist == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)}));
endmodule

bind bp_predictor bp_predictor_chk #(.HIST_W(HIST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .pred_valid(pred_valid),
    .pred_taken(pred_taken), .ghist(ghist), .upd_valid(upd_valid), .upd_taken(upd_taken),
    .upd_hist(upd_hist), .upd_mispredict(upd_mispredict));

// File: tb/tb_bp_predictor.sv
module tb_bp_predictor;
    localparam int HIST_W = 8;
    localparam int ENT    = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lookup_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0, upd_mispredict = 1'b0;
    logic [31:0] lookup_pc = '0, upd_pc = '0;
    logic [HIST_W-1:0] upd_hist = '0;
    logic pv_t, pt_t, pv_g, pt_g;
    logic [HIST_W-1:0] gh_t, gh_g;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    int m_bim [ENT], m_gsh [ENT], m_cho [ENT], m_gsel [ENT];
    logic [HIST_W-1:0] m_ghr_t, m_ghr_g;

    always #5 clk = ~clk;

    bp_predictor #(.SCHEME(bp_pkg::SCHEME_TOURNAMENT), .ENTRIES(ENT), .HIST_W(HIST_W)) dut (
        .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
        .pred_valid(pv_t), .pred_taken(pt_t), .ghist(gh_t), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist), .upd_mispredict(upd_mispredict));

    bp_predictor #(.SCHEME(bp_pkg::SCHEME_GSELECT), .ENTRIES(ENT), .HIST_W(HIST_W)) dut_gsel (
        .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
        .pred_valid(pv_g), .pred_taken(pt_g), .ghist(gh_g), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist), .upd_mispredict(upd_mispredict));

    function automatic int idx_bim(logic [31:0] pc);
        return int'(pc[10:2]);
    endfunction
    function automatic int idx_gsh(logic [31:0] pc, logic [HIST_W-1:0] h);
        return int'(pc[10:2] ^ {1'b0, h});
    endfunction
    function automatic int idx_gsel(logic [31:0] pc, logic [HIST_W-1:0] h);
        return int'({pc[6:2], h[3:0]});
    endfunction
    function automatic int sat(int c, bit up);
        if (up) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge; check one rising edge later.
    task automatic step(string tag, bit lv, logic [31:0] lpc, bit uv, logic [31:0] upc,
                        bit ut, logic [HIST_W-1:0] uh, bit um);
        bit e_t, e_g, bp, gp;
        int bi, gi;
        lookup_valid = lv; lookup_pc = lpc; upd_valid = uv; upd_pc = upc;
        upd_taken = ut; upd_hist = uh; upd_mispredict = um;
        // Predictions use pre-update state (R9); R5/R6 formulas
        bi  = idx_bim(lpc);
        e_t = (m_cho[bi] >= 2) ? (m_gsh[idx_gsh(lpc, m_ghr_t)] >= 2) : (m_bim[bi] >= 2);
        e_g = m_gsel[idx_gsel(lpc, m_ghr_g)] >= 2;
        if (uv && um) begin
            m_ghr_t = {uh[HIST_W-2:0], ut};
            m_ghr_g = {uh[HIST_W-2:0], ut};
        end else if (lv) begin
            m_ghr_t = {m_ghr_t[HIST_W-2:0], e_t};
            m_ghr_g = {m_ghr_g[HIST_W-2:0], e_g};
        end
        if (uv) begin
            bi = idx_bim(upc); gi = idx_gsh(upc, uh);
            bp = m_bim[bi] >= 2; gp = m_gsh[gi] >= 2;
            if (bp != gp) m_cho[bi] = sat(m_cho[bi], gp == ut);   // R10
            m_bim[bi] = sat(m_bim[bi], ut);
            m_gsh[gi] = sat(m_gsh[gi], ut);
            gi = idx_gsel(upc, uh);
            m_gsel[gi] = sat(m_gsel[gi], ut);
        end
        @(negedge clk);
        chk(tag, "pred_valid", int'(pv_t), int'(lv));
        chk(tag, "pred_valid gsel", int'(pv_g), int'(lv));
        if (lv) begin
            chk(tag, "tournament pred", int'(pt_t), int'(e_t));
            chk(tag, "gselect pred", int'(pt_g), int'(e_g));
        end
        chk((uv && um) ? "R8" : tag, "ghist", int'(gh_t), int'(m_ghr_t));
        chk((uv && um) ? "R8" : tag, "ghist gsel", int'(gh_g), int'(m_ghr_g));
    endtask

    task automatic train(logic [31:0] pc, bit t, int n);
        for (int i = 0; i < n; i++) step("R3", 0, '0, 1, pc, t, '0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < ENT; i++) begin
            m_bim[i] = 1; m_gsh[i] = 1; m_cho[i] = 1; m_gsel[i] = 1;
        end
        m_ghr_t = '0; m_ghr_g = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "pred_valid after reset", int'(pv_t), 0);
        chk("R1", "ghist after reset", int'(gh_t), 0);
        chk("R1", "ghist gsel after reset", int'(gh_g), 0);
        step("R1", 1, 32'h100, 0, '0, 0, '0, 0);
        // R3: saturate high, then step down through the threshold
        train(32'h200, 1, 5);
        step("R3", 1, 32'h200, 0, '0, 0, '0, 0);
        train(32'h200, 0, 1);
        step("R3", 1, 32'h200, 0, '0, 0, '0, 0);
        train(32'h200, 0, 1);
        step("R3", 1, 32'h200, 0, '0, 0, '0, 0);
        // R3: saturate low, then one taken must not cross over
        train(32'h200, 0, 4);
        train(32'h200, 1, 1);
        step("R3", 1, 32'h200, 0, '0, 0, '0, 0);
        // R4: neighbours in the same byte keep their counters
        train(32'h300, 1, 2);
        step("R4", 1, 32'h304, 0, '0, 0, '0, 0);
        step("R4", 1, 32'h308, 0, '0, 0, '0, 0);
        step("R4", 1, 32'h30C, 0, '0, 0, '0, 0);
        step("R4", 1, 32'h300, 0, '0, 0, '0, 0);
        // R9: lookup and update of the same entry in one cycle
        train(32'h400, 1, 1);
        step("R9", 1, 32'h400, 1, 32'h400, 1, 8'h00, 0);
        step("R9", 1, 32'h400, 0, '0, 0, '0, 0);
        // R8: restore wins over a same-cycle lookup shift
        step("R8", 1, 32'h500, 1, 32'h504, 1, 8'hA5, 1);
        step("R7", 1, 32'h508, 0, '0, 0, '0, 0);
        // R6/R10: component disagreement trains the chooser toward gshare
        for (int i = 0; i < 4; i++) step("R10", 0, '0, 1, 32'h600, 1, 8'h3C, 0);
        for (int i = 0; i < 3; i++) step("R10", 0, '0, 1, 32'h600, 0, 8'h00, 0);
        step("R6", 1, 32'h600, 1, 32'h600, 0, 8'h3C, 1);
        // Random mix over a small PC window to force aliasing (R5, R6, R7, R8, R10)
        for (int i = 0; i < 4000; i++) begin
            bit lv, uv, um;
            logic [31:0] lpc, upc;
            lv  = ($urandom_range(0, 3) != 0);
            uv  = ($urandom_range(0, 2) != 0);
            um  = uv && ($urandom_range(0, 3) == 0);
            lpc = 32'h1000 + ($urandom_range(0, 255) << 2);
            upc = 32'h1000 + ($urandom_range(0, 255) << 2);
            step(um ? "R8" : "R5", lv, lpc, uv, upc, 1'($urandom_range(0, 1)),
                 HIST_W'($urandom), um);
        end
        lookup_valid = 0; upd_valid = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule